// File: doc/BRIEF.md
# Earliest Bank Preparation Selector

This block sits in a DRAM command scheduler and answers one question per scheduling decision: which queued request, or which banks, should be served next so the data bus stays as busy as possible. A single `start` pulse samples a flat queue of requests and the per-bank state: open row, and the earliest cycles at which an activate, a precharge, a read burst or a write burst may be issued. One cycle later `done` strobes and the registered result appears.

The search runs in two passes. The first pass looks for the oldest request that hits an open row and can send its burst with no gap on the bus. If none exists, the second pass works out, for every bank that has a request waiting, when it could be activated and when its burst could then follow. It marks the best banks in a per-rank mask. Banks that could still burst without a gap come first. Failing that, the banks with the earliest activate time are marked. A flag tells whether the precharge and activate work stays hidden behind the traffic already on the bus. Issuing commands and updating the timing state are left to the surrounding scheduler. Each rank mask word holds at most 32 banks.

Top module: `ebp_selector`

## Requirements
- R1: The gap-free burst cycle is `max(next_burst + X, now)`, where X is `T_CS` when `dir_switch` is 1 and 0 otherwise.
- R2: A queue entry is a row hit when it is valid, its rank's bit in `rank_avail` is 1, its bank has a row open whose number equals the entry's row, and the bank's allowed cycle for the entry's own command type (`bank_rd_ok` if `q_rd` is 1, else `bank_wr_ok`) is at or before the gap-free burst cycle. When row hits exist, `hit_found` is 1 and `hit_idx` is the lowest entry index (entry 0 is the oldest).
- R3: When a row hit is found, `prep_found`, `hidden_prep` and every bit of `bank_mask` are 0.
- R4: A bank is waiting when at least one valid entry targets it and that entry's rank is available. Only waiting banks can have a bit set in `bank_mask`.
- R5: A waiting bank's activate cycle is `max(act_ok, max(pre_ok, now) + T_RP)` when it has a row open, and `max(act_ok, now)` when it has no row open.
- R6: A waiting bank's burst cycle is `max(D, activate + T_RCD)`, where D is `bank_rd_ok` when `bus_rd` is 1 and `bank_wr_ok` otherwise. The bank is seamless when its burst cycle is at or before the gap-free burst cycle.
- R7: If any waiting bank is seamless, the mask holds exactly the seamless waiting banks. Otherwise it holds exactly the waiting banks whose activate cycle equals the minimum among waiting banks.
- R8: `hidden_prep` is 1 when the activate cycle of the last marked bank, in scan order (rank-major, ascending bank), is at or before the gap-free burst cycle minus `T_RCD`, with the difference saturating at 0.
- R9: With no row hit and no waiting bank, `prep_found` is 0 and the mask is all zero. With no row hit and at least one waiting bank, `prep_found` is 1.
- R10: After reset all outputs are 0. `done` is 1 exactly in the cycle after a `start` cycle. The result outputs change only on `start` and hold otherwise, whatever the other inputs do.
- R11: Bank b of rank r is bit `r*BPR + b` of `bank_mask`. Queue fields and bank state are packed the same way: entry i at slice i of each queue vector, and bank r*BPR+b at slice r*BPR+b of each bank vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Sample inputs and compute a decision |
| now | input | TIME_W | Current cycle |
| next_burst | input | TIME_W | Earliest cycle for the next burst on the bus |
| dir_switch | input | 1 | Bus is turning between read and write |
| bus_rd | input | 1 | Current bus direction is read |
| rank_avail | input | NR | Per-rank availability (not refreshing) |
| q_valid | input | QD | Queue entry valid |
| q_rank | input | QD*RK_W | Rank of each entry |
| q_bank | input | QD*BK_W | Bank of each entry |
| q_row | input | QD*ROW_W | Row of each entry |
| q_rd | input | QD | Entry is a read (1) or write (0) |
| bank_open | input | NB | Bank has a row open |
| bank_row | input | NB*ROW_W | Open row per bank |
| bank_act_ok | input | NB*TIME_W | Earliest activate cycle per bank |
| bank_pre_ok | input | NB*TIME_W | Earliest precharge cycle per bank |
| bank_rd_ok | input | NB*TIME_W | Earliest read burst cycle per bank |
| bank_wr_ok | input | NB*TIME_W | Earliest write burst cycle per bank |
| done | output | 1 | Result valid strobe |
| hit_found | output | 1 | A gap-free row hit was found |
| hit_idx | output | QI_W | Index of the chosen row hit |
| prep_found | output | 1 | Bank preparation candidates found |
| hidden_prep | output | 1 | Preparation is hidden behind bus traffic |
| bank_mask | output | NB | Per-rank bank candidate mask |

## Verification
The bench builds the block with 2 ranks of 4 banks, an 8-entry queue, 4-bit rows, and timing constants T_RP=5, T_RCD=4, T_CS=3. With only four row values and narrow time windows, the random sweeps often produce hits, ties in the minimum activate cycle, and cases where a seamless bank follows an earlier-activating one. This tests the mask-clearing order and the scan-order dependence of the hidden flag. Some batches force every row to miss and compress all times into a few cycles, so that the preparation pass runs on nearly every decision.

// File: rtl/ebp_pkg.sv
package ebp_pkg;
  localparam int TIME_W = 16;
  typedef logic [TIME_W-1:0] cyc_t;

  function automatic cyc_t cyc_max(input cyc_t a, input cyc_t b);
    return (a > b) ? a : b;
  endfunction

  // cycle at which a burst lands with no bus gap
  function automatic cyc_t seam_time(input cyc_t nb, input cyc_t now,
                                     input logic sw, input cyc_t tcs);
    return cyc_max(nb + (sw ? tcs : cyc_t'(0)), now);
  endfunction

  // earliest activate, with a precharge first when a row is open
  function automatic cyc_t act_time(input logic opened, input cyc_t act_ok,
                                    input cyc_t pre_ok, input cyc_t now,
                                    input cyc_t trp);
    return opened ? cyc_max(act_ok, cyc_max(pre_ok, now) + trp)
                  : cyc_max(act_ok, now);
  endfunction

  // latest activate that still leaves no bus gap
  function automatic cyc_t gapfree_act(input cyc_t seam, input cyc_t trcd);
    return (seam > trcd) ? seam - trcd : cyc_t'(0);
  endfunction
endpackage

// File: rtl/ebp_queue_scan.sv
module ebp_queue_scan
  import ebp_pkg::*;
#(
  parameter int NR    = 2,
  parameter int BPR   = 8,
  parameter int QD    = 16,
  parameter int ROW_W = 14,
  localparam int NB   = NR * BPR,
  localparam int RK_W = (NR > 1) ? $clog2(NR) : 1,
  localparam int BK_W = (BPR > 1) ? $clog2(BPR) : 1,
  localparam int NB_W = (NB > 1) ? $clog2(NB) : 1,
  localparam int QI_W = (QD > 1) ? $clog2(QD) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [QD-1:0]         q_valid,
  input  logic [QD*RK_W-1:0]    q_rank,
  input  logic [QD*BK_W-1:0]    q_bank,
  input  logic [QD*ROW_W-1:0]   q_row,
  input  logic [QD-1:0]         q_rd,
  input  logic [NR-1:0]         rank_avail,
  input  logic [NB-1:0]         bank_open,
  input  logic [NB*ROW_W-1:0]   bank_row,
  input  cyc_t [NB-1:0]         rd_ok,
  input  cyc_t [NB-1:0]         wr_ok,
  input  cyc_t                  seam,
  output logic                  hit,
  output logic [QI_W-1:0]       hit_idx,
  output logic [NB-1:0]         waiting
);
  logic [NB_W-1:0] ent_g [QD];
  logic [QD-1:0]   ent_live;
  logic [QD-1:0]   cand;

  genvar i;
  generate
    for (i = 0; i < QD; i++) begin : g_ent
      logic [RK_W-1:0]  rk;
      logic [BK_W-1:0]  bk;
      logic [ROW_W-1:0] rw;
      cyc_t             own_ok;
      assign rk = q_rank[i*RK_W +: RK_W];
      assign bk = q_bank[i*BK_W +: BK_W];
      assign rw = q_row[i*ROW_W +: ROW_W];
      assign ent_g[i] = NB_W'(int'(rk) * BPR + int'(bk));
      assign ent_live[i] = q_valid[i] && (int'(rk) < NR) && (int'(bk) < BPR)
                           && rank_avail[rk];
      assign own_ok = q_rd[i] ? rd_ok[ent_g[i]] : wr_ok[ent_g[i]];
      assign cand[i] = ent_live[i] && bank_open[ent_g[i]]
                       && (bank_row[ent_g[i]*ROW_W +: ROW_W] == rw)
                       && (own_ok <= seam);
    end
  endgenerate

  // oldest candidate wins: scan downwards so the lowest index is kept
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = QD - 1; k >= 0; k--) begin
      if (cand[k]) begin
        hit     = 1'b1;
        hit_idx = QI_W'(k);
      end
    end
  end

  always_comb begin
    waiting = '0;
    for (int k = 0; k < QD; k++) begin
      if (ent_live[k]) waiting[ent_g[k]] = 1'b1;
    end
  end

  // R2
  hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (q_valid[hit_idx] && (waiting != '0)));
endmodule

// File: rtl/ebp_prep_search.sv
module ebp_prep_search
  import ebp_pkg::*;
#(
  parameter int NR    = 2,
  parameter int BPR   = 8,
  parameter int T_RP  = 14,
  parameter int T_RCD = 14,
  localparam int NB   = NR * BPR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] waiting,
  input  logic [NB-1:0] bank_open,
  input  cyc_t [NB-1:0] act_ok,
  input  cyc_t [NB-1:0] pre_ok,
  input  cyc_t [NB-1:0] rd_ok,
  input  cyc_t [NB-1:0] wr_ok,
  input  logic          bus_rd,
  input  cyc_t          now,
  input  cyc_t          seam,
  output logic [NB-1:0] mask,
  output logic          hidden,
  output logic          found
);
  cyc_t        act_at [NB];
  cyc_t        col_at [NB];
  logic [NB-1:0] seamless;
  cyc_t        hmax;
  cyc_t        min_act;
  logic        found_seam;

  assign hmax = gapfree_act(seam, cyc_t'(T_RCD));

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_bank
      assign act_at[g] = act_time(bank_open[g], act_ok[g], pre_ok[g], now,
                                  cyc_t'(T_RP));
      assign col_at[g] = cyc_max(bus_rd ? rd_ok[g] : wr_ok[g],
                                 act_at[g] + cyc_t'(T_RCD));
      assign seamless[g] = (col_at[g] <= seam);
    end
  endgenerate

  // rank-major, ascending-bank scan
  always_comb begin
    found_seam = 1'b0;
    min_act    = '1;
    mask       = '0;
    hidden     = 1'b0;
    found      = 1'b0;
    for (int k = 0; k < NB; k++) begin
      if (waiting[k] && (seamless[k] || (!found_seam && act_at[k] <= min_act))) begin
        if (!found_seam && (seamless[k] || act_at[k] < min_act)) mask = '0;
        found_seam = found_seam | seamless[k];
        hidden     = (act_at[k] <= hmax);
        mask[k]    = 1'b1;
        min_act    = act_at[k];
        found      = 1'b1;
      end
    end
  end

  // R4
  mask_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask & ~waiting) == '0);
  // R7
  seam_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((seamless & waiting) != '0) |-> ((mask & ~seamless) == '0));
endmodule

// File: rtl/ebp_selector.sv
module ebp_selector
  import ebp_pkg::*;
#(
  parameter int NR    = 2,
  parameter int BPR   = 8,
  parameter int QD    = 16,
  parameter int ROW_W = 14,
  parameter int T_RP  = 14,
  parameter int T_RCD = 14,
  parameter int T_CS  = 2,
  localparam int NB   = NR * BPR,
  localparam int RK_W = (NR > 1) ? $clog2(NR) : 1,
  localparam int BK_W = (BPR > 1) ? $clog2(BPR) : 1,
  localparam int QI_W = (QD > 1) ? $clog2(QD) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [TIME_W-1:0]     now,
  input  logic [TIME_W-1:0]     next_burst,
  input  logic                  dir_switch,
  input  logic                  bus_rd,
  input  logic [NR-1:0]         rank_avail,
  input  logic [QD-1:0]         q_valid,
  input  logic [QD*RK_W-1:0]    q_rank,
  input  logic [QD*BK_W-1:0]    q_bank,
  input  logic [QD*ROW_W-1:0]   q_row,
  input  logic [QD-1:0]         q_rd,
  input  logic [NB-1:0]         bank_open,
  input  logic [NB*ROW_W-1:0]   bank_row,
  input  logic [NB*TIME_W-1:0]  bank_act_ok,
  input  logic [NB*TIME_W-1:0]  bank_pre_ok,
  input  logic [NB*TIME_W-1:0]  bank_rd_ok,
  input  logic [NB*TIME_W-1:0]  bank_wr_ok,
  output logic                  done,
  output logic                  hit_found,
  output logic [QI_W-1:0]       hit_idx,
  output logic                  prep_found,
  output logic                  hidden_prep,
  output logic [NB-1:0]         bank_mask
);
  cyc_t [NB-1:0] act_v, pre_v, rd_v, wr_v;
  cyc_t          seam;
  logic          hit_c;
  logic [QI_W-1:0] idx_c;
  logic [NB-1:0] waiting;
  logic [NB-1:0] mask_c;
  logic          hidden_c, found_c;

  assign act_v = bank_act_ok;
  assign pre_v = bank_pre_ok;
  assign rd_v  = bank_rd_ok;
  assign wr_v  = bank_wr_ok;
  assign seam  = seam_time(next_burst, now, dir_switch, cyc_t'(T_CS));

  ebp_queue_scan #(.NR(NR), .BPR(BPR), .QD(QD), .ROW_W(ROW_W)) u_scan (
    .clk(clk), .rst_n(rst_n),
    .q_valid(q_valid), .q_rank(q_rank), .q_bank(q_bank), .q_row(q_row),
    .q_rd(q_rd), .rank_avail(rank_avail), .bank_open(bank_open),
    .bank_row(bank_row), .rd_ok(rd_v), .wr_ok(wr_v), .seam(seam),
    .hit(hit_c), .hit_idx(idx_c), .waiting(waiting)
  );

  ebp_prep_search #(.NR(NR), .BPR(BPR), .T_RP(T_RP), .T_RCD(T_RCD)) u_prep (
    .clk(clk), .rst_n(rst_n),
    .waiting(waiting), .bank_open(bank_open), .act_ok(act_v), .pre_ok(pre_v),
    .rd_ok(rd_v), .wr_ok(wr_v), .bus_rd(bus_rd), .now(now), .seam(seam),
    .mask(mask_c), .hidden(hidden_c), .found(found_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      hit_found   <= 1'b0;
      hit_idx     <= '0;
      prep_found  <= 1'b0;
      hidden_prep <= 1'b0;
      bank_mask   <= '0;
    end else begin
      done <= start;
      if (start) begin
        hit_found   <= hit_c;
        hit_idx     <= hit_c ? idx_c : '0;
        prep_found  <= !hit_c && found_c;
        hidden_prep <= !hit_c && hidden_c;
        bank_mask   <= hit_c ? '0 : mask_c;
      end
    end
  end

  // R3
  hit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_found |-> (bank_mask == '0 && !hidden_prep && !prep_found));
  // R8
  hidden_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hidden_prep |-> (prep_found && bank_mask != '0));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!done && $stable(bank_mask) && $stable(hit_found)));
endmodule

// File: tb/ebp_selector_test.sv
`timescale 1ns/1ps
module ebp_selector_test;
  localparam int NR = 2, BPR = 4, QD = 8, ROW_W = 4;
  localparam int TRP = 5, TRCD = 4, TCS = 3;
  localparam int NB = NR * BPR, TW = 16, RK_W = 1, BK_W = 2, QI_W = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [TW-1:0] now_s, nb_s;
  logic dir_switch, bus_rd;
  logic [NR-1:0] rank_avail;
  logic [QD-1:0] q_valid, q_rd;
  logic [QD*RK_W-1:0] q_rank;
  logic [QD*BK_W-1:0] q_bank;
  logic [QD*ROW_W-1:0] q_row;
  logic [NB-1:0] bank_open;
  logic [NB*ROW_W-1:0] bank_row;
  logic [NB*TW-1:0] bank_act_ok, bank_pre_ok, bank_rd_ok, bank_wr_ok;
  logic done, hit_found, prep_found, hidden_prep;
  logic [QI_W-1:0] hit_idx;
  logic [NB-1:0] bank_mask;

  ebp_selector #(.NR(NR), .BPR(BPR), .QD(QD), .ROW_W(ROW_W),
                 .T_RP(TRP), .T_RCD(TRCD), .T_CS(TCS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .now(now_s), .next_burst(nb_s),
    .dir_switch(dir_switch), .bus_rd(bus_rd), .rank_avail(rank_avail),
    .q_valid(q_valid), .q_rank(q_rank), .q_bank(q_bank), .q_row(q_row),
    .q_rd(q_rd), .bank_open(bank_open), .bank_row(bank_row),
    .bank_act_ok(bank_act_ok), .bank_pre_ok(bank_pre_ok),
    .bank_rd_ok(bank_rd_ok), .bank_wr_ok(bank_wr_ok),
    .done(done), .hit_found(hit_found), .hit_idx(hit_idx),
    .prep_found(prep_found), .hidden_prep(hidden_prep), .bank_mask(bank_mask)
  );

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  // scenario state
  int t_now, t_nb, sw, brd;
  int ra [NR];
  int qv [QD], qrk [QD], qbk [QD], qrow [QD], qr [QD];
  int bo [NB], brow [NB], bact [NB], bpre [NB], brdok [NB], bwrok [NB];
  int e_hit, e_idx, e_prep, e_hid, e_mask;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive();
    now_s = TW'(t_now); nb_s = TW'(t_nb);
    dir_switch = sw[0]; bus_rd = brd[0];
    for (int r = 0; r < NR; r++) rank_avail[r] = ra[r][0];
    for (int i = 0; i < QD; i++) begin
      q_valid[i] = qv[i][0]; q_rd[i] = qr[i][0];
      q_rank[i*RK_W +: RK_W] = RK_W'(qrk[i]);
      q_bank[i*BK_W +: BK_W] = BK_W'(qbk[i]);
      q_row[i*ROW_W +: ROW_W] = ROW_W'(qrow[i]);
    end
    for (int g = 0; g < NB; g++) begin
      bank_open[g] = bo[g][0];
      bank_row[g*ROW_W +: ROW_W] = ROW_W'(brow[g]);
      bank_act_ok[g*TW +: TW] = TW'(bact[g]);
      bank_pre_ok[g*TW +: TW] = TW'(bpre[g]);
      bank_rd_ok[g*TW +: TW] = TW'(brdok[g]);
      bank_wr_ok[g*TW +: TW] = TW'(bwrok[g]);
    end
  endtask

  // expected result worked out from the requirement text
  task automatic model();
    int seam, hmax, minact, anyseam, lastseam;
    int wait_b [NB];
    int act [NB];
    int sm [NB];
    seam = imax(t_nb + (sw != 0 ? TCS : 0), t_now);             // R1
    hmax = (seam > TRCD) ? seam - TRCD : 0;
    e_hit = 0; e_idx = 0; e_prep = 0; e_hid = 0; e_mask = 0;
    for (int i = QD - 1; i >= 0; i--) begin                     // R2
      int g;
      g = qrk[i] * BPR + qbk[i];
      if (qv[i] != 0 && ra[qrk[i]] != 0 && bo[g] != 0 && brow[g] == qrow[i] &&
          ((qr[i] != 0) ? brdok[g] : bwrok[g]) <= seam) begin
        e_hit = 1; e_idx = i;
      end
    end
    if (e_hit != 0) return;                                     // R3
    for (int g = 0; g < NB; g++) wait_b[g] = 0;
    for (int i = 0; i < QD; i++)
      if (qv[i] != 0 && ra[qrk[i]] != 0) wait_b[qrk[i]*BPR + qbk[i]] = 1;  // R4
    anyseam = 0; minact = 1 << 30; lastseam = -1;
    for (int g = 0; g < NB; g++) begin
      act[g] = (bo[g] != 0) ? imax(bact[g], imax(bpre[g], t_now) + TRP)
                            : imax(bact[g], t_now);             // R5
      sm[g] = (imax(brd != 0 ? brdok[g] : bwrok[g], act[g] + TRCD) <= seam); // R6
      if (wait_b[g] != 0) begin
        if (sm[g] != 0) begin anyseam = 1; lastseam = g; end
        if (act[g] < minact) minact = act[g];
      end
    end
    for (int g = 0; g < NB; g++) begin                          // R7
      if (wait_b[g] != 0 && ((anyseam != 0) ? (sm[g] != 0) : (act[g] == minact)))
        e_mask = e_mask | (1 << g);
    end
    e_prep = (e_mask != 0);                                     // R9
    if (anyseam != 0) e_hid = (act[lastseam] <= hmax);          // R8
    else if (e_prep != 0) e_hid = (minact <= hmax);
  endtask

  task automatic gen(input int mode);
    int spread;
    spread = (mode == 3) ? 4 : 40;
    t_now = 20 + int'($urandom % 20);
    t_nb  = t_now - 10 + int'($urandom % 30);
    sw = int'($urandom % 2); brd = int'($urandom % 2);
    for (int r = 0; r < NR; r++) ra[r] = ($urandom % 5) != 0;
    for (int g = 0; g < NB; g++) begin
      bo[g] = int'($urandom % 2); brow[g] = int'($urandom % 4);
      bact[g] = t_now - 10 + int'($urandom % spread);
      bpre[g] = t_now - 10 + int'($urandom % spread);
      brdok[g] = t_now - 10 + int'($urandom % spread);
      bwrok[g] = t_now - 10 + int'($urandom % spread);
    end
    for (int i = 0; i < QD; i++) begin
      qv[i] = (mode == 2) ? (($urandom % 4) == 0) : (($urandom % 3) != 0);
      qrk[i] = int'($urandom % NR); qbk[i] = int'($urandom % BPR);
      qrow[i] = (mode == 1 || mode == 3) ? 4 + int'($urandom % 4) : int'($urandom % 4);
      qr[i] = int'($urandom % 2);
    end
  endtask

  task automatic run_case();
    logic [NB-1:0] m0;
    logic h0;
    @(negedge clk);
    drive(); model();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done === 1'b1, "R10 done", done, 1);
    chk(hit_found === e_hit[0], "R1/R2 hit_found", hit_found, e_hit);
    if (e_hit != 0) chk(int'(hit_idx) == e_idx, "R2 hit_idx", hit_idx, e_idx);
    chk(int'(bank_mask) == e_mask, "R7/R11 mask", bank_mask, e_mask);
    chk(prep_found === e_prep[0], "R3/R9 prep_found", prep_found, e_prep);
    chk(hidden_prep === e_hid[0], "R8 hidden", hidden_prep, e_hid);
    // change inputs without start: outputs must hold
    m0 = bank_mask; h0 = hit_found;
    gen(0); drive();
    @(negedge clk);
    chk(done === 1'b0, "R10 done low", done, 0);
    chk(bank_mask === m0 && hit_found === h0, "R10 hold", bank_mask, m0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    gen(0); drive();
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && hit_found === 1'b0 && bank_mask === '0 &&
        prep_found === 1'b0 && hidden_prep === 1'b0, "R10 reset", int'(bank_mask), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // empty queue: nothing waiting
    gen(0);
    for (int i = 0; i < QD; i++) qv[i] = 0;
    run_case();
    // all ranks unavailable: nothing waiting
    gen(1); ra[0] = 0; ra[1] = 0;
    run_case();
    // directed seamless-after-earlier case across ranks
    gen(1);
    t_now = 30; t_nb = 40; sw = 0; brd = 1; ra[0] = 1; ra[1] = 1;
    for (int g = 0; g < NB; g++) begin
      bo[g] = 0; bact[g] = 50; bpre[g] = 0; brdok[g] = 0; bwrok[g] = 0;
    end
    bact[1] = 31; bact[6] = 20; brdok[6] = 36;
    for (int i = 0; i < QD; i++) qv[i] = 0;
    qv[0] = 1; qrk[0] = 0; qbk[0] = 1;
    qv[3] = 1; qrk[3] = 1; qbk[3] = 2;
    run_case();
    for (int n = 0; n < 2000; n++) begin
      gen(n % 4);
      run_case();
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule